// File: doc/BRIEF.md
# Indexed Block Register Slave for a Clock Fan-out Controller

This block is a two-wire serial slave that keeps the configuration bytes of an eight-output clock fan-out device. A host selects the slave with write address byte 0xDC, gives a starting register index and a byte count, and then streams data bytes. Each data byte lands at the index, and the index then steps forward. To read, the host writes only the index, issues a repeated START with address byte 0xDD, and clocks bytes out. The first byte returned is the stored read-length register, and the data bytes follow from the chosen index until the host declines a byte.

SCL and SDA are sampled by a fast system clock through synchronizer chains. START and STOP are found as SDA edges while SCL is high. SDA is an open-drain line: the slave only asserts `sda_oe` to pull it low. The decoded control fields feed the clock tree directly. The revision nibble of the identity register comes from an input.

The controller is a single state machine with these states: IDLE, GET_ADDR, ACK_ADDR, GET_INDEX, ACK_INDEX, GET_COUNT, ACK_COUNT, GET_DATA, ACK_DATA, SEND, HOST_ACK and SKIP. Its transitions are:

- START from any state goes to GET_ADDR, and STOP from any state goes to IDLE.
- At the end of the eighth bit, GET_ADDR goes to ACK_ADDR when the address matches and to SKIP when it does not.
- ACK_ADDR goes to GET_INDEX for a write and to SEND for a read.
- The write path runs GET_INDEX→ACK_INDEX→GET_COUNT→ACK_COUNT→GET_DATA→ACK_DATA, and ACK_DATA returns to GET_DATA.
- SEND goes to HOST_ACK after eight bits.
- HOST_ACK goes to SEND when the host acknowledged and to SKIP when it did not.
- SKIP waits for STOP or START.

Top module: `smb_regbank_slave`

## Requirements
- R1: The slave acknowledges address byte 0xDC (write) and 0xDD (read). It leaves the ACK slot of any other address released, and ignores that transfer until the next START or STOP.
- R2: After reset the register values are:
  - control byte 0x07;
  - output-enable byte 0xFF;
  - stoppable byte 0x00;
  - device-ID byte 0x83;
  - read-length byte 0x07.
- R3: A write transfer is address 0xDC, index N, count X, then data bytes. Every byte is acknowledged, and the data bytes are stored at N, N+1, and so on. The count byte does not limit or change storage.
- R4: A read transfer is address 0xDC, index N, repeated START, address 0xDD. The slave sends the read-length register, then the registers from index N upward, one per byte the host acknowledges. A host NACK ends the sending.
- R5: Register 6 is the read-length register. It is writable, and reads return its current value as the first byte.
- R6: Register 0 drives these outputs and reads bits 4:3 as 0:
  - bit 7 to `pd_hiz`;
  - bit 6 to `stop_hiz`;
  - bit 5 to `pd_active_high`;
  - bit 2 to `bw_low`;
  - bit 1 to `pll_mode`;
  - bit 0 to `div_full`.
- R7: In register 1, bit i drives `out_en[i]`. In register 2, bit i drives `out_stoppable[i]`.
- R8: Register 4 reads `{rev_id, 4'b0001}`. Writes to it are acknowledged and change nothing. Register 5 (device ID) is writable.
- R9: Register 3 and every index of 7 or above read 0x00. Writes to them are acknowledged and ignored.
- R10: A STOP or START in the middle of a byte discards that byte and keeps the bytes already stored. A START always restarts the address phase.
- R11: `sda_oe` changes only while SCL is low, and it is asserted only in slave ACK slots and in slave-sent zero bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| rev_id | input | 4 | Revision nibble reported in register 4 bits 7:4 |
| pd_hiz | output | 1 | Power-down output drive: 0 driven, 1 high impedance |
| stop_hiz | output | 1 | Stop output drive: 0 driven, 1 high impedance |
| pd_active_high | output | 1 | Power-down input polarity select |
| bw_low | output | 1 | Loop bandwidth select: 1 low, 0 high |
| pll_mode | output | 1 | 1 loop mode, 0 fan-out bypass |
| div_full | output | 1 | 1 input frequency, 0 half frequency |
| out_en | output | 8 | Per-output enables |
| out_stoppable | output | 8 | Per-output stoppable flags (0 free-run) |

## Verification
The two functions that can meet in the same window are the commit of a received byte and the bus-condition detector. A STOP or repeated START can arrive a few bits into a byte, just after the previous byte's ACK has committed a write. The bench provokes this with a STOP four bits into the second data byte of a write, and with a repeated START three bits into a data byte that is followed by a complete new write. It judges the result at the ports: the control outputs must show the committed byte, must not show the partial one, and must show the new write.

// File: rtl/smbr_pkg.sv
`timescale 1ns/1ps
package smbr_pkg;
    localparam int BYTE_W = 8;

    localparam logic [7:0] IDX_CTRL      = 8'd0;
    localparam logic [7:0] IDX_OEN       = 8'd1;
    localparam logic [7:0] IDX_STOPPABLE = 8'd2;
    localparam logic [7:0] IDX_RSVD      = 8'd3;
    localparam logic [7:0] IDX_IDENT     = 8'd4;
    localparam logic [7:0] IDX_DEVID     = 8'd5;
    localparam logic [7:0] IDX_RDLEN     = 8'd6;

    typedef enum logic [3:0] {
        ST_IDLE, ST_GET_ADDR, ST_ACK_ADDR, ST_GET_INDEX, ST_ACK_INDEX,
        ST_GET_COUNT, ST_ACK_COUNT, ST_GET_DATA, ST_ACK_DATA,
        ST_SEND, ST_HOST_ACK, ST_SKIP
    } smbr_state_e;

    typedef struct packed {
        logic pd_hiz;
        logic stop_hiz;
        logic pd_active_high;
        logic bw_low;
        logic pll_mode;
        logic div_full;
    } smbr_ctrl_t;
endpackage

// File: rtl/smbr_line_sync.sv
`timescale 1ns/1ps
module smbr_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= {pipe_q[STAGES-1:0], din};
    end

    assign lvl  = pipe_q[STAGES-1];
    assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fall = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/smbr_regfile.sv
`timescale 1ns/1ps
module smbr_regfile
    import smbr_pkg::*;
#(
    parameter logic [7:0] DEV_ID_RST = 8'h83,
    parameter logic [3:0] VENDOR_ID  = 4'h1,
    parameter logic [7:0] RDLEN_RST  = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [7:0]        rd_idx,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [3:0]        rev_id,
    output smbr_ctrl_t        ctrl,
    output logic [BYTE_W-1:0] oen,
    output logic [BYTE_W-1:0] stoppable,
    output logic [BYTE_W-1:0] rdlen
);
    localparam smbr_ctrl_t CTRL_RST = '{pd_hiz: 1'b0, stop_hiz: 1'b0, pd_active_high: 1'b0,
                                        bw_low: 1'b1, pll_mode: 1'b1, div_full: 1'b1};

    smbr_ctrl_t        ctrl_q;
    logic [BYTE_W-1:0] oen_q, stp_q, devid_q, rdlen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= CTRL_RST;
            oen_q   <= '1;
            stp_q   <= '0;
            devid_q <= DEV_ID_RST;
            rdlen_q <= RDLEN_RST;
        end else if (wr_en) begin
            case (wr_idx)
                IDX_CTRL:      ctrl_q  <= '{pd_hiz: wr_data[7], stop_hiz: wr_data[6],
                                           pd_active_high: wr_data[5], bw_low: wr_data[2],
                                           pll_mode: wr_data[1], div_full: wr_data[0]};
                IDX_OEN:       oen_q   <= wr_data;
                IDX_STOPPABLE: stp_q   <= wr_data;
                IDX_DEVID:     devid_q <= wr_data;
                IDX_RDLEN:     rdlen_q <= wr_data;
                default:       ;
            endcase
        end
    end

    always_comb begin
        case (rd_idx)
            IDX_CTRL:      rd_data = {ctrl_q.pd_hiz, ctrl_q.stop_hiz, ctrl_q.pd_active_high, 2'b00,
                                      ctrl_q.bw_low, ctrl_q.pll_mode, ctrl_q.div_full};
            IDX_OEN:       rd_data = oen_q;
            IDX_STOPPABLE: rd_data = stp_q;
            IDX_RSVD:      rd_data = '0;
            IDX_IDENT:     rd_data = {rev_id, VENDOR_ID};
            IDX_DEVID:     rd_data = devid_q;
            IDX_RDLEN:     rd_data = rdlen_q;
            default:       rd_data = '0;
        endcase
    end

    assign ctrl      = ctrl_q;
    assign oen       = oen_q;
    assign stoppable = stp_q;
    assign rdlen     = rdlen_q;

    assert_rdlen_only_by_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rdlen_q != $past(rdlen_q)) |-> $past(wr_en && wr_idx == IDX_RDLEN));

    assert_oen_only_by_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (oen_q != $past(oen_q)) |-> $past(wr_en && wr_idx == IDX_OEN));

    assert_stp_only_by_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stp_q != $past(stp_q)) |-> $past(wr_en && wr_idx == IDX_STOPPABLE));
endmodule

// File: rtl/smb_regbank_slave.sv
`timescale 1ns/1ps
module smb_regbank_slave
    import smbr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h6E,
    parameter logic [7:0] DEV_ID_RST  = 8'h83,
    parameter logic [3:0] VENDOR_ID   = 4'h1,
    parameter logic [7:0] RDLEN_RST   = 8'h07,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe,
    input  logic [3:0] rev_id,
    output logic       pd_hiz,
    output logic       stop_hiz,
    output logic       pd_active_high,
    output logic       bw_low,
    output logic       pll_mode,
    output logic       div_full,
    output logic [7:0] out_en,
    output logic [7:0] out_stoppable
);
    localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

    logic scl_lvl, scl_rise, scl_fall, sda_lvl, sda_rise, sda_fall;
    logic start_det, stop_det, byte_done;

    smbr_state_e       state_q, state_d;
    logic [3:0]        bit_cnt_q;
    logic [BYTE_W-1:0] shreg_q, txsh_q, rd_data, rdlen;
    logic [7:0]        ptr_q;
    logic              rd_mode_q, ack_q, wr_en;
    smbr_ctrl_t        ctrl;

    smbr_line_sync #(.STAGES(SYNC_STAGES)) u_scl (
        .clk(clk), .rst_n(rst_n), .din(scl_in), .lvl(scl_lvl), .rise(scl_rise), .fall(scl_fall));
    smbr_line_sync #(.STAGES(SYNC_STAGES)) u_sda (
        .clk(clk), .rst_n(rst_n), .din(sda_in), .lvl(sda_lvl), .rise(sda_rise), .fall(sda_fall));

    assign start_det = scl_lvl & sda_fall;
    assign stop_det  = scl_lvl & sda_rise;
    assign byte_done = scl_fall && (bit_cnt_q == LAST_BIT);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start_det)     state_d = ST_GET_ADDR;
        else if (stop_det) state_d = ST_IDLE;
        else begin
            unique case (state_q)
                ST_IDLE:      ;
                ST_GET_ADDR:  if (byte_done) state_d = (shreg_q[7:1] == DEV_ADDR) ? ST_ACK_ADDR : ST_SKIP;
                ST_ACK_ADDR:  if (scl_fall)  state_d = rd_mode_q ? ST_SEND : ST_GET_INDEX;
                ST_GET_INDEX: if (byte_done) state_d = ST_ACK_INDEX;
                ST_ACK_INDEX: if (scl_fall)  state_d = ST_GET_COUNT;
                ST_GET_COUNT: if (byte_done) state_d = ST_ACK_COUNT;
                ST_ACK_COUNT: if (scl_fall)  state_d = ST_GET_DATA;
                ST_GET_DATA:  if (byte_done) state_d = ST_ACK_DATA;
                ST_ACK_DATA:  if (scl_fall)  state_d = ST_GET_DATA;
                ST_SEND:      if (byte_done) state_d = ST_HOST_ACK;
                ST_HOST_ACK:  if (scl_fall)  state_d = ack_q ? ST_SEND : ST_SKIP;
                ST_SKIP:      ;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // state register and byte datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bit_cnt_q <= '0;
            shreg_q   <= '0;
            txsh_q    <= '0;
            ptr_q     <= '0;
            rd_mode_q <= 1'b0;
            ack_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start_det) begin
                bit_cnt_q <= '0;
            end else if (!stop_det) begin
                unique case (state_q)
                    ST_GET_ADDR, ST_GET_INDEX, ST_GET_COUNT, ST_GET_DATA: begin
                        if (scl_rise) begin
                            bit_cnt_q <= bit_cnt_q + 4'd1;
                            shreg_q   <= {shreg_q[BYTE_W-2:0], sda_lvl};
                        end
                        if (byte_done && state_q == ST_GET_ADDR)  rd_mode_q <= shreg_q[0];
                        if (byte_done && state_q == ST_GET_INDEX) ptr_q     <= shreg_q;
                        if (byte_done && state_q == ST_GET_DATA)  ptr_q     <= ptr_q + 8'd1;
                    end
                    ST_ACK_ADDR, ST_ACK_INDEX, ST_ACK_COUNT, ST_ACK_DATA: begin
                        if (scl_fall) begin
                            bit_cnt_q <= '0;
                            if (state_q == ST_ACK_ADDR && rd_mode_q) txsh_q <= rdlen;
                        end
                    end
                    ST_SEND: begin
                        if (scl_rise) bit_cnt_q <= bit_cnt_q + 4'd1;
                        if (scl_fall && bit_cnt_q != 4'd0 && bit_cnt_q != LAST_BIT)
                            txsh_q <= {txsh_q[BYTE_W-2:0], 1'b0};
                    end
                    ST_HOST_ACK: begin
                        if (scl_rise) ack_q <= ~sda_lvl;
                        if (scl_fall && ack_q) begin
                            txsh_q    <= rd_data;
                            ptr_q     <= ptr_q + 8'd1;
                            bit_cnt_q <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_ACK_ADDR, ST_ACK_INDEX, ST_ACK_COUNT, ST_ACK_DATA: sda_oe = 1'b1;
            ST_SEND: sda_oe = ~txsh_q[BYTE_W-1];
            default: sda_oe = 1'b0;
        endcase
        wr_en = (state_q == ST_GET_DATA) && byte_done && !start_det && !stop_det;
    end

    smbr_regfile #(.DEV_ID_RST(DEV_ID_RST), .VENDOR_ID(VENDOR_ID), .RDLEN_RST(RDLEN_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(ptr_q), .wr_data(shreg_q),
        .rd_idx(ptr_q), .rd_data(rd_data), .rev_id(rev_id), .ctrl(ctrl),
        .oen(out_en), .stoppable(out_stoppable), .rdlen(rdlen));

    assign pd_hiz         = ctrl.pd_hiz;
    assign stop_hiz       = ctrl.stop_hiz;
    assign pd_active_high = ctrl.pd_active_high;
    assign bw_low         = ctrl.bw_low;
    assign pll_mode       = ctrl.pll_mode;
    assign div_full       = ctrl.div_full;

    assert_sda_moves_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_lvl);

    assert_send_only_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEND) |-> rd_mode_q);

    assert_stop_to_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (state_q == ST_IDLE));

    assert_start_restarts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state_q == ST_GET_ADDR && bit_cnt_q == 4'd0));

    assert_bitcnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt_q <= LAST_BIT);
endmodule

// File: tb/tb_smb_regbank_slave.sv
`timescale 1ns/1ps
module tb_smb_regbank_slave;
    localparam int Q = 8;

    logic clk = 1'b0, rst_n = 1'b0, scl_drv = 1'b1, sda_host = 1'b1;
    logic sda_oe, sda_bus;
    logic [3:0] rev_id = 4'hA;
    logic pd_hiz, stop_hiz, pd_active_high, bw_low, pll_mode, div_full;
    logic [7:0] out_en, out_stoppable;

    assign sda_bus = sda_host & ~sda_oe;
    always #10 clk = ~clk;

    smb_regbank_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_drv), .sda_in(sda_bus), .sda_oe(sda_oe),
        .rev_id(rev_id), .pd_hiz(pd_hiz), .stop_hiz(stop_hiz), .pd_active_high(pd_active_high),
        .bw_low(bw_low), .pll_mode(pll_mode), .div_full(div_full),
        .out_en(out_en), .out_stoppable(out_stoppable));

    int n_chk = 0, n_bad = 0, oe_glitch = 0, host_slot_drive = 0;
    bit done = 1'b0;
    logic prev_oe = 1'b0;
    logic [7:0] exp_q[$];
    string tag_q[$];
    logic [7:0] got_b;
    event got_ev;

    task automatic tick(input int n); repeat (n) @(negedge clk); endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    task automatic push(input logic [7:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    // scoreboard monitor
    initial forever begin
        @(got_ev);
        if (exp_q.size() == 0) begin
            chk("R4 unexpected byte", {24'd0, got_b}, 32'hFFFF_FFFF);
        end else begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            chk(t, {24'd0, got_b}, {24'd0, e});
        end
    end

    // R11 observer: SDA enable may only move while SCL is low
    always @(posedge clk) begin
        prev_oe <= sda_oe;
        if (rst_n && sda_oe !== prev_oe && scl_drv) oe_glitch++;
    end

    task automatic bus_start();
        sda_host = 1'b1; scl_drv = 1'b1; tick(Q);
        sda_host = 1'b0; tick(Q);
        scl_drv = 1'b0;
    endtask

    task automatic bus_rstart();
        sda_host = 1'b1; tick(Q);
        scl_drv = 1'b1; tick(Q);
        sda_host = 1'b0; tick(Q);
        scl_drv = 1'b0;
    endtask

    task automatic bus_stop();
        sda_host = 1'b0; tick(Q);
        scl_drv = 1'b1; tick(Q);
        sda_host = 1'b1; tick(Q);
    endtask

    task automatic put_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_host = b[i]; tick(Q);
            scl_drv = 1'b1; tick(Q / 2);
            if (sda_oe) host_slot_drive++;
            tick(Q / 2);
            scl_drv = 1'b0;
        end
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        put_bits(b, 8);
        sda_host = 1'b1; tick(Q);
        scl_drv = 1'b1; tick(Q / 2);
        ack = ~sda_bus;
        tick(Q / 2);
        scl_drv = 1'b0;
    endtask

    task automatic get_byte(input logic host_ack);
        logic [7:0] b = '0;
        sda_host = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(Q);
            scl_drv = 1'b1; tick(Q / 2);
            b = {b[6:0], sda_bus};
            tick(Q / 2);
            scl_drv = 1'b0;
        end
        got_b = b;
        ->got_ev;
        sda_host = ~host_ack; tick(Q);
        scl_drv = 1'b1; tick(Q);
        scl_drv = 1'b0;
        sda_host = 1'b1;
    endtask

    task automatic wr_txn(input string tag, input logic [7:0] idx, input int n,
                          input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
        logic a;
        logic [5:0] acks = '0;
        logic [7:0] d [3];
        d[0] = b0; d[1] = b1; d[2] = b2;
        bus_start();
        put_byte(8'hDC, a);   acks[0] = a;
        put_byte(idx, a);     acks[1] = a;
        put_byte(8'(n), a);   acks[2] = a;
        for (int k = 0; k < n; k++) begin
            put_byte(d[k], a); acks[3 + k] = a;
        end
        bus_stop();
        chk(tag, {26'd0, acks}, {26'd0, 6'((1 << (3 + n)) - 1)});
    endtask

    task automatic rd_txn(input string tag, input logic [7:0] idx, input int nbytes);
        logic a;
        logic [2:0] acks;
        bus_start();
        put_byte(8'hDC, a); acks[0] = a;
        put_byte(idx, a);   acks[1] = a;
        bus_rstart();
        put_byte(8'hDD, a); acks[2] = a;
        for (int k = 0; k < nbytes; k++) get_byte(k != nbytes - 1);
        bus_stop();
        chk(tag, {29'd0, acks}, 32'd7);
    endtask

    initial begin
        tick(150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R3 actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic a;
        tick(4);
        rst_n = 1'b1;
        tick(6);

        // R2 reset values at the ports
        chk("R2 ctrl fields", {26'd0, pd_hiz, stop_hiz, pd_active_high, bw_low, pll_mode, div_full}, 32'h07);
        chk("R2 out_en", {24'd0, out_en}, 32'hFF);
        chk("R2 out_stoppable", {24'd0, out_stoppable}, 32'h00);
        chk("R11 idle release", {31'd0, sda_oe}, 32'd0);

        // R1 foreign address: ACK slot released, following byte ignored
        bus_start();
        put_byte(8'hA0, a);
        chk("R1 foreign address nack", {31'd0, a}, 32'd0);
        put_byte(8'h01, a);
        chk("R1 ignored byte nack", {31'd0, a}, 32'd0);
        bus_stop();
        chk("R1 outputs untouched", {24'd0, out_en}, 32'hFF);

        // R3 / R7 multi-byte write
        wr_txn("R3 write acks", 8'd1, 2, 8'h5A, 8'h3C, 8'h00);
        chk("R7 out_en", {24'd0, out_en}, 32'h5A);
        chk("R7 out_stoppable", {24'd0, out_stoppable}, 32'h3C);

        // R6 control fields
        wr_txn("R6 write acks", 8'd0, 1, 8'hFF, 8'h00, 8'h00);
        chk("R6 ctrl fields", {26'd0, pd_hiz, stop_hiz, pd_active_high, bw_low, pll_mode, div_full}, 32'h3F);

        // R4 / R8 / R9 full readback from index 0
        push(8'h07, "R4 length byte first");
        push(8'hE7, "R6 reg0 readback, bits 4:3 zero");
        push(8'h5A, "R4 reg1");
        push(8'h3C, "R4 reg2");
        push(8'h00, "R9 reg3 reads zero");
        push(8'hA1, "R8 identity byte");
        push(8'h83, "R2 device id default");
        push(8'h07, "R2 read length default");
        rd_txn("R4 read acks", 8'd0, 8);

        // R8 read-only identity, writable device id
        wr_txn("R8 write acks", 8'd4, 2, 8'hFF, 8'h42, 8'h00);
        push(8'h07, "R4 length byte");
        push(8'hA1, "R8 identity unchanged");
        push(8'h42, "R8 device id written");
        rd_txn("R8 read acks", 8'd4, 3);

        // R5 read length register
        wr_txn("R5 write acks", 8'd6, 1, 8'h02, 8'h00, 8'h00);
        push(8'h02, "R5 new length first");
        push(8'h42, "R5 reg5");
        push(8'h02, "R5 reg6");
        rd_txn("R5 read acks", 8'd5, 3);

        // R9 unimplemented and reserved indexes
        wr_txn("R9 write acks", 8'd9, 1, 8'h77, 8'h00, 8'h00);
        wr_txn("R9 reserved write acks", 8'd3, 1, 8'h66, 8'h00, 8'h00);
        push(8'h02, "R9 length byte");
        push(8'h00, "R9 index 9 zero");
        push(8'h00, "R9 index 10 zero");
        rd_txn("R9 read acks", 8'd9, 3);
        push(8'h02, "R9 length byte");
        push(8'h00, "R9 reserved reads zero");
        rd_txn("R9 reserved read acks", 8'd3, 2);

        // R10 STOP four bits into a data byte
        bus_start();
        put_byte(8'hDC, a);
        put_byte(8'd1, a);
        put_byte(8'd3, a);
        put_byte(8'h11, a);
        chk("R10 first data ack", {31'd0, a}, 32'd1);
        put_bits(8'hEE, 4);
        bus_stop();
        chk("R10 committed byte kept", {24'd0, out_en}, 32'h11);
        chk("R10 partial byte dropped", {24'd0, out_stoppable}, 32'h3C);

        // R10 repeated START three bits into a data byte, then a fresh write
        bus_start();
        put_byte(8'hDC, a);
        put_byte(8'd2, a);
        put_byte(8'd1, a);
        put_bits(8'hFF, 3);
        bus_rstart();
        put_byte(8'hDC, a);
        chk("R10 restart address ack", {31'd0, a}, 32'd1);
        put_byte(8'd2, a);
        put_byte(8'd1, a);
        put_byte(8'h77, a);
        bus_stop();
        chk("R10 write after restart", {24'd0, out_stoppable}, 32'h77);

        tick(10);
        chk("R11 SDA enable moved only with SCL low", oe_glitch, 0);
        chk("R11 no drive in host data bits", host_slot_drive, 0);
        chk("R4 scoreboard drained", exp_q.size(), 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule